// File: doc/BRIEF.md
# CAN Overload Condition Detector

This block sits beside the frame state machine of a CAN controller and decides when an overload frame must be started. On every cycle with an active sample strobe it looks at three things together: the sampled bus level, the field the state machine reports, and the bit index inside that field. When a dominant level shows up at a position where the protocol calls for an overload frame, the block raises a single-cycle request together with a code that names the cause.

Three positions can trigger a request. The first is either of the two leading bits of intermission. The second is the final (seventh) bit of end-of-frame, and only while a frame is being received. The third is the final (eighth) bit of either an error delimiter or an overload delimiter. All other bit positions and fields are ignored. The frame state machine consumes the request and sends the overload flag itself.

Top module: `ovld_detect`

## Requirements
- R1: After a synchronous active-low reset, `ovl_req` is 0 and `ovl_cause` is 0.
- R2: A dominant sample (bus_bit 0) with `fld` = 1 (intermission) and `bit_idx` 0 or 1 gives `ovl_req` = 1 with `ovl_cause` = 0.
- R3: A dominant sample in intermission at `bit_idx` 2 or higher gives no request.
- R4: A dominant sample with `fld` = 2 (end-of-frame), `bit_idx` 6, and `rx_dir` = 1 gives `ovl_req` = 1 with `ovl_cause` = 1.
- R5: A dominant end-of-frame sample gives no request when `rx_dir` = 0 or when `bit_idx` is anything other than 6.
- R6: A dominant sample with `fld` = 3 (error delimiter) or `fld` = 4 (overload delimiter) and `bit_idx` 7 gives `ovl_req` = 1 with `ovl_cause` = 2. Other delimiter bit indices give no request.
- R7: A recessive sample (bus_bit 1) never gives a request, whatever the field and index.
- R8: Inputs are evaluated only on cycles where `smp_stb` is 1. A dominant level at a trigger position has no effect without the strobe.
- R9: The request appears in the cycle after the strobed sample and lasts exactly one cycle. While `ovl_req` is 0, `ovl_cause` reads 0.
- R10: `fld` = 0 (no tracked field) and the unused codes 5 to 7 never give a request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_stb | input | 1 | Marks a cycle that carries a new sampled bit |
| bus_bit | input | 1 | Sampled bus level, 0 dominant, 1 recessive |
| fld | input | 3 | Current field: 0 none, 1 intermission, 2 end-of-frame, 3 error delimiter, 4 overload delimiter |
| bit_idx | input | 4 | Zero-based bit index inside the current field |
| rx_dir | input | 1 | 1 while the controller is receiving the frame |
| ovl_req | output | 1 | One-cycle request to start an overload frame |
| ovl_cause | output | 2 | Cause while ovl_req is 1: 0 intermission, 1 end-of-frame, 2 delimiter |

## Verification
The only state is the output register, so any internal fault appears on `ovl_req` or `ovl_cause` in the cycle right after the strobed sample that caused it. The bench can compare every cycle. A matcher with the wrong index window or the wrong direction gate shows up as a missing pulse or an extra pulse at one bit position. A wrong cause encoding shows up as a bad code on a correct pulse. A pulse that fails to clear shows up one cycle later as a request after an idle cycle.

// File: rtl/ovld_pkg.sv
// Package: ovld_pkg
// Shared widths, field codes and cause codes for the overload detector.
// Assumes the frame state machine uses these field encodings.
package ovld_pkg;
    localparam int FLD_W   = 3;
    localparam int IDX_W   = 4;
    localparam int CAUSE_W = 2;
    localparam int N_COND  = 3;

    typedef enum logic [FLD_W-1:0] {
        FLD_NONE   = 3'd0,
        FLD_IFS    = 3'd1,
        FLD_EOF    = 3'd2,
        FLD_ERRDLM = 3'd3,
        FLD_OVLDLM = 3'd4
    } fld_e;

    typedef enum logic [CAUSE_W-1:0] {
        CAUSE_IFS = 2'd0,
        CAUSE_EOF = 2'd1,
        CAUSE_DLM = 2'd2
    } cause_e;

    // Per-condition table: primary field, alternate field, index window, direction gate.
    function automatic logic [FLD_W-1:0] cond_fld_a(input int k);
        case (k)
            0:       return FLD_IFS;
            1:       return FLD_EOF;
            default: return FLD_ERRDLM;
        endcase
    endfunction

    function automatic logic [FLD_W-1:0] cond_fld_b(input int k);
        case (k)
            0:       return FLD_IFS;
            1:       return FLD_EOF;
            default: return FLD_OVLDLM;
        endcase
    endfunction

    function automatic int cond_lo(input int k, input int eof_last, input int dlm_last);
        case (k)
            0:       return 0;
            1:       return eof_last;
            default: return dlm_last;
        endcase
    endfunction

    function automatic int cond_hi(input int k, input int ifs_bits, input int eof_last,
                                   input int dlm_last);
        case (k)
            0:       return ifs_bits - 1;
            1:       return eof_last;
            default: return dlm_last;
        endcase
    endfunction

    function automatic bit cond_rx_only(input int k);
        return (k == 1);
    endfunction
endpackage

// File: rtl/ovld_cond_match.sv
// Module: ovld_cond_match
// Flags a dominant strobed sample that falls inside one field pair and one
// index window, optionally gated by receive direction. Purely combinational.
// Assumes bit_idx is zero-based within the field.
module ovld_cond_match
    import ovld_pkg::*;
#(
    parameter logic [FLD_W-1:0] FLD_A   = FLD_IFS,
    parameter logic [FLD_W-1:0] FLD_B   = FLD_IFS,
    parameter int               IDX_LO  = 0,
    parameter int               IDX_HI  = 1,
    parameter bit               RX_ONLY = 1'b0
) (
    input  logic             smp_stb,
    input  logic             bus_bit,
    input  logic [FLD_W-1:0] fld,
    input  logic [IDX_W-1:0] bit_idx,
    input  logic             rx_dir,
    output logic             hit
);
    localparam logic [IDX_W-1:0] LO = IDX_W'(IDX_LO);
    localparam logic [IDX_W-1:0] HI = IDX_W'(IDX_HI);

    logic fld_ok, idx_ok, dir_ok;

    // Decode field, index window and direction for this condition.
    always_comb begin
        fld_ok = (fld == FLD_A) || (fld == FLD_B);
        idx_ok = (bit_idx >= LO) && (bit_idx <= HI);
        dir_ok = RX_ONLY ? rx_dir : 1'b1;
        hit    = smp_stb && !bus_bit && fld_ok && idx_ok && dir_ok;
    end
endmodule

// File: rtl/ovld_req_reg.sv
// Module: ovld_req_reg
// Encodes the per-condition hit vector into a cause code and registers the
// request pulse. Assumes at most one hit at a time (fields are exclusive).
module ovld_req_reg
    import ovld_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_COND-1:0]  hit,
    output logic               req_q,
    output logic [CAUSE_W-1:0] cause_q
);
    logic [CAUSE_W-1:0] cause_d;

    // Turn the hit vector into a cause code, defaulting to 0.
    always_comb begin
        cause_d = CAUSE_IFS;
        if (hit[1])      cause_d = CAUSE_EOF;
        else if (hit[2]) cause_d = CAUSE_DLM;
    end

    // Register the pulse and its cause. Cause is cleared when there is no hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q   <= 1'b0;
            cause_q <= '0;
        end else begin
            req_q   <= |hit;
            cause_q <= (|hit) ? cause_d : '0;
        end
    end

    // R9: cause is zero whenever no request is pending
    a_r9_cause_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_q |-> cause_q == '0);
    // Field exclusivity: never more than one condition at once
    a_r6_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));
endmodule

// File: rtl/ovld_detect.sv
// Module: ovld_detect (top)
// Watches strobed bus samples with field/index tags from the frame FSM and
// requests an overload frame at the protocol-defined positions.
// Assumes fld and bit_idx are valid whenever smp_stb is high.
module ovld_detect
    import ovld_pkg::*;
#(
    parameter int IFS_BITS = 2,
    parameter int EOF_LAST = 6,
    parameter int DLM_LAST = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               smp_stb,
    input  logic               bus_bit,
    input  logic [FLD_W-1:0]   fld,
    input  logic [IDX_W-1:0]   bit_idx,
    input  logic               rx_dir,
    output logic               ovl_req,
    output logic [CAUSE_W-1:0] ovl_cause
);
    logic [N_COND-1:0] hit;

    for (genvar k = 0; k < N_COND; k++) begin : g_cond
        ovld_cond_match #(
            .FLD_A  (cond_fld_a(k)),
            .FLD_B  (cond_fld_b(k)),
            .IDX_LO (cond_lo(k, EOF_LAST, DLM_LAST)),
            .IDX_HI (cond_hi(k, IFS_BITS, EOF_LAST, DLM_LAST)),
            .RX_ONLY(cond_rx_only(k))
        ) u_match (
            .smp_stb(smp_stb),
            .bus_bit(bus_bit),
            .fld    (fld),
            .bit_idx(bit_idx),
            .rx_dir (rx_dir),
            .hit    (hit[k])
        );
    end

    ovld_req_reg u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .hit    (hit),
        .req_q  (ovl_req),
        .cause_q(ovl_cause)
    );

    // R8: no strobe, no request
    a_r8_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_stb |=> !ovl_req);
    // R7: recessive never requests
    a_r7_recessive: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_stb && bus_bit) |=> !ovl_req);
    // R2: early intermission dominant requests with cause 0
    a_r2_ifs: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_stb && !bus_bit && fld == FLD_IFS && bit_idx < IDX_W'(IFS_BITS))
        |=> (ovl_req && ovl_cause == CAUSE_IFS));
    // R4: last end-of-frame bit while receiving
    a_r4_eof_rx: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_stb && !bus_bit && fld == FLD_EOF && bit_idx == IDX_W'(EOF_LAST) && rx_dir)
        |=> (ovl_req && ovl_cause == CAUSE_EOF));
    // R5: end-of-frame while transmitting never requests
    a_r5_eof_tx: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_stb && fld == FLD_EOF && !rx_dir) |=> !ovl_req);
    // R6: last delimiter bit
    a_r6_dlm: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_stb && !bus_bit && (fld == FLD_ERRDLM || fld == FLD_OVLDLM)
         && bit_idx == IDX_W'(DLM_LAST))
        |=> (ovl_req && ovl_cause == CAUSE_DLM));
    // R10: untracked field codes never request
    a_r10_no_field: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_stb && (fld == FLD_NONE || fld > FLD_OVLDLM)) |=> !ovl_req);
endmodule

// File: tb/ovld_detect_test.sv
// Scoreboard bench: drive() pushes expected outputs, the monitor pops and
// compares them shortly after each rising edge.
module ovld_detect_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_stb = 1'b0;
    logic       bus_bit = 1'b1;
    logic [2:0] fld = 3'd0;
    logic [3:0] bit_idx = 4'd0;
    logic       rx_dir = 1'b0;
    logic       ovl_req;
    logic [1:0] ovl_cause;

    int    n_run = 0;
    int    n_fail = 0;
    bit    mon_on = 1'b0;
    bit    done = 1'b0;
    logic [2:0] exp_q[$];
    string      tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    ovld_detect uut (
        .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .bus_bit(bus_bit),
        .fld(fld), .bit_idx(bit_idx), .rx_dir(rx_dir),
        .ovl_req(ovl_req), .ovl_cause(ovl_cause)
    );

    task automatic check(input string tag, input logic [2:0] got, input logic [2:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: req/cause got %b/%0d expected %b/%0d",
                     tag, got[2], got[1:0], exp[2], exp[1:0]);
        end
    endtask

    // Drive one cycle at the falling edge and queue its expected result.
    task automatic drive(input logic s, input logic b, input logic [2:0] f,
                         input logic [3:0] i, input logic r,
                         input logic er, input logic [1:0] ec, input string tag);
        @(negedge clk);
        smp_stb = s; bus_bit = b; fld = f; bit_idx = i; rx_dir = r;
        exp_q.push_back({er, ec});
        tag_q.push_back(tag);
    endtask

    // Monitor: compare after the edge that registered the queued stimulus.
    always begin
        @(posedge clk);
        #1;
        if (mon_on && exp_q.size() > 0)
            check(tag_q.pop_front(), {ovl_req, ovl_cause}, exp_q.pop_front());
    end

    initial begin
        repeat (3) @(negedge clk);
        #2;
        check("R1", {ovl_req, ovl_cause}, 3'b000);
        @(negedge clk);
        rst_n = 1'b1;
        mon_on = 1'b1;

        // R2: intermission bits 0 and 1
        drive(1, 0, 3'd1, 4'd0, 0, 1, 2'd0, "R2");
        drive(0, 1, 3'd0, 4'd0, 0, 0, 2'd0, "R9");
        drive(1, 0, 3'd1, 4'd1, 1, 1, 2'd0, "R2");
        drive(0, 0, 3'd1, 4'd1, 1, 0, 2'd0, "R8");
        // R3: intermission bit 2 and later
        drive(1, 0, 3'd1, 4'd2, 0, 0, 2'd0, "R3");
        drive(1, 0, 3'd1, 4'd5, 1, 0, 2'd0, "R3");
        // R4 / R5: end-of-frame
        drive(1, 0, 3'd2, 4'd6, 1, 1, 2'd1, "R4");
        drive(0, 1, 3'd0, 4'd0, 1, 0, 2'd0, "R9");
        drive(1, 0, 3'd2, 4'd6, 0, 0, 2'd0, "R5");
        drive(1, 0, 3'd2, 4'd5, 1, 0, 2'd0, "R5");
        drive(1, 0, 3'd2, 4'd7, 1, 0, 2'd0, "R5");
        drive(0, 0, 3'd2, 4'd6, 1, 0, 2'd0, "R8");
        // R6: delimiters
        drive(1, 0, 3'd3, 4'd7, 0, 1, 2'd2, "R6");
        drive(1, 0, 3'd4, 4'd7, 1, 1, 2'd2, "R6");
        drive(1, 0, 3'd3, 4'd6, 0, 0, 2'd0, "R6");
        drive(1, 0, 3'd4, 4'd0, 1, 0, 2'd0, "R6");
        drive(0, 0, 3'd4, 4'd7, 1, 0, 2'd0, "R8");
        // R7: recessive at every trigger position
        drive(1, 1, 3'd1, 4'd0, 1, 0, 2'd0, "R7");
        drive(1, 1, 3'd2, 4'd6, 1, 0, 2'd0, "R7");
        drive(1, 1, 3'd3, 4'd7, 1, 0, 2'd0, "R7");
        // R10: untracked fields at every index
        for (int f = 0; f < 8; f++) begin
            if (f >= 1 && f <= 4) continue;
            for (int i = 0; i < 16; i += 3)
                drive(1, 0, 3'(f), 4'(i), 1, 0, 2'd0, "R10");
        end
        // R9: back-to-back triggers, then pulse clears
        drive(1, 0, 3'd1, 4'd0, 1, 1, 2'd0, "R9");
        drive(1, 0, 3'd2, 4'd6, 1, 1, 2'd1, "R9");
        drive(1, 0, 3'd4, 4'd7, 0, 1, 2'd2, "R9");
        drive(0, 1, 3'd0, 4'd0, 0, 0, 2'd0, "R9");
        // R1: reset during a pending trigger clears the output
        drive(1, 0, 3'd1, 4'd0, 0, 1, 2'd0, "R2");
        drive(0, 1, 3'd0, 4'd0, 0, 0, 2'd0, "R9");
        @(negedge clk);
        mon_on = 1'b0;
        smp_stb = 1'b1; bus_bit = 1'b0; fld = 3'd1; bit_idx = 4'd0;
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", {ovl_req, ovl_cause}, 3'b000);
        smp_stb = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (5000) @(posedge clk);
                n_run++;
                n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule